// File: doc/BRIEF.md
# Memory Startup and Command Sequencer

This block sits in front of a synchronous single-port memory that needs a controlled bring-up. After the system reset is released, it lets a few clock cycles go by. It then holds the memory's active-low initialisation reset for a minimum number of cycles. Next it waits out an access blackout, and only after that does it raise `host_ready`.

Once ready, each host request with `host_req` high becomes exactly one memory command in the same cycle. The command is a read strobe or a write strobe, both active low. The host byte mask is active high, and the block inverts it into the memory's active-low byte enables. Requests that arrive before ready are dropped and produce no strobe. A low `sys_rst_n` returns the sequencer to its first phase at any time.

Top module: `mem_boot_seq`

## Requirements
- R1: While `sys_rst_n` is low, and on the first cycle after it rises, `host_ready` is 0, `mem_rst_n` is 1, and both `mem_rd_n` and `mem_wr_n` are 1.
- R2: After `sys_rst_n` rises, `mem_rst_n` stays high for WARM_CYC clock cycles (default 2) before it goes low.
- R3: `mem_rst_n` stays low for exactly RST_CYC consecutive cycles (default 10), then returns high.
- R4: After `mem_rst_n` returns high, `host_ready` rises only once INIT_CYC cycles (default 128) have passed. No strobe goes low before `host_ready` is 1.
- R5: `mem_rd_n` and `mem_wr_n` are never both 0.
- R6: When `host_ready` is 1 and `host_req` is 1, exactly one strobe is 0 in that cycle. `mem_rd_n` is 0 if `host_we`=0, and `mem_wr_n` is 0 if `host_we`=1. `mem_addr` equals `host_addr` and `mem_din` equals `host_wdata` in that cycle.
- R7: `mem_be_n[i]` = ~`host_be[i]` for each byte lane i. Bit 3 covers data bits 31:24 and bit 0 covers bits 7:0.
- R8: With no request, or while not ready, both strobes are 1 (no operation).
- R9: A low `sys_rst_n` at any time drops `host_ready` and restarts the full sequence from the warm-up phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| host_req | input | 1 | Host request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_be | input | DW/8 | Active-high byte mask |
| host_ready | output | 1 | Sequencer ready to accept requests |
| mem_rst_n | output | 1 | Memory initialisation reset, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_din | output | DW | Memory write data |
| mem_be_n | output | DW/8 | Memory byte enables, active low |

## Verification
The bench builds the block with its default values: WARM_CYC=2, RST_CYC=10 and INIT_CYC=128. Because of that, the exact edges of each phase are measured against the real 2/10/128 cycle budget rather than a shortened one. Requests are driven during every phase to show they are blocked. A mid-operation system reset is issued to show the whole sequence restarts from the beginning.

// File: rtl/mem_boot_seq.sv
module mem_boot_seq #(
  parameter int AW       = 15,
  parameter int DW       = 32,
  parameter int WARM_CYC = 2,
  parameter int RST_CYC  = 10,
  parameter int INIT_CYC = 128
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW/8-1:0] host_be,
  output logic          host_ready,
  output logic          mem_rst_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_din,
  output logic [DW/8-1:0] mem_be_n
);
  localparam int MAXC = (INIT_CYC > RST_CYC) ? ((INIT_CYC > WARM_CYC) ? INIT_CYC : WARM_CYC)
                                             : ((RST_CYC > WARM_CYC) ? RST_CYC : WARM_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_WARM, S_RST, S_INIT, S_RDY} state_t;
  state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      state <= S_WARM;
      cnt   <= '0;
    end else begin
      case (state)
        S_WARM: if (cnt == CW'(WARM_CYC - 1)) begin state <= S_RST;  cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_RST:  if (cnt == CW'(RST_CYC - 1))  begin state <= S_INIT; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_INIT: if (cnt == CW'(INIT_CYC - 1)) begin state <= S_RDY;  cnt <= '0; end
                else cnt <= cnt + 1'b1;
        default: cnt <= '0;
      endcase
    end
  end

  logic go;
  assign host_ready = (state == S_RDY);
  assign mem_rst_n  = (state != S_RST);
  assign go         = host_ready && host_req;
  assign mem_rd_n   = !(go && !host_we);
  assign mem_wr_n   = !(go && host_we);
  assign mem_addr   = host_addr;
  assign mem_din    = host_wdata;
  assign mem_be_n   = ~host_be;
endmodule

// File: rtl/mem_boot_seq_chk.sv
module mem_boot_seq_chk #(
  parameter int AW = 15,
  parameter int DW = 32
) (
  input logic clk,
  input logic sys_rst_n,
  input logic host_req,
  input logic host_we,
  input logic [AW-1:0] host_addr,
  input logic host_ready,
  input logic mem_rst_n,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic [AW-1:0] mem_addr
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R5
  AST_NO_STROBE_EARLY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!host_ready) |-> (mem_rd_n && mem_wr_n)); // R4
  AST_RST_NOT_READY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!mem_rst_n) |-> !host_ready); // R3
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (host_ready && host_req) |-> ((mem_rd_n != mem_wr_n) && (mem_wr_n == !host_we)
                                   && (mem_addr == host_addr))); // R6
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!host_req) |-> (mem_rd_n && mem_wr_n)); // R8
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!sys_rst_n)
    host_ready |=> host_ready); // R9
endmodule

bind mem_boot_seq mem_boot_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .sys_rst_n(sys_rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ready(host_ready), .mem_rst_n(mem_rst_n),
  .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr)
);

// File: tb/mem_boot_seq_tb_top.sv
`timescale 1ns/1ps
module mem_boot_seq_tb_top;
  localparam int AW = 15, DW = 32;
  logic clk = 0, sys_rst_n = 0, host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [3:0] host_be = '0;
  logic host_ready, mem_rst_n, mem_rd_n, mem_wr_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_din;
  logic [3:0] mem_be_n;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mem_boot_seq dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #5; endtask

  int low_cnt, ready_at, strobe_early;

  task automatic t_bringup();
    sys_rst_n = 0; host_req = 1; host_we = 0;
    #5;
    chk("R1 ready", host_ready, 0);
    chk("R1 rst", mem_rst_n, 1);
    chk("R1 strobes", {mem_rd_n, mem_wr_n}, 2'b11);
    @(negedge clk); sys_rst_n = 1;
    // edges after release: WARM for 2 edges
    step(); chk("R2 warm edge1", mem_rst_n, 1);
    chk("R1 first cycle", {host_ready, mem_rd_n, mem_wr_n}, 3'b011);
    step(); chk("R2 rst low after warm", mem_rst_n, 0);
    low_cnt = 1; strobe_early = 0;
    while (!mem_rst_n) begin
      step();
      if (!mem_rst_n) low_cnt++;
      if (low_cnt > 20) break;
    end
    chk("R3 reset length", low_cnt, 10);
    ready_at = 0;
    while (!host_ready && ready_at < 200) begin
      ready_at++;
      if (!mem_rd_n || !mem_wr_n) strobe_early++;
      step();
    end
    chk("R4 blackout length", ready_at, 128);
    chk("R4 no early strobe", strobe_early, 0);
    chk("R4 ready", host_ready, 1);
  endtask

  task automatic t_access();
    host_req = 1; host_we = 0; host_addr = 15'h1234; host_be = 4'b0101;
    #1;
    chk("R6 read rd", mem_rd_n, 0);
    chk("R6 read wr", mem_wr_n, 1);
    chk("R6 addr", mem_addr, 15'h1234);
    chk("R7 be map", mem_be_n, 4'b1010);
    host_we = 1; host_wdata = 32'hCAFE_F00D; host_be = 4'b1000; host_addr = 15'h7FFF;
    #1;
    chk("R6 write wr", mem_wr_n, 0);
    chk("R6 write rd", mem_rd_n, 1);
    chk("R6 data", mem_din, 32'hCAFE_F00D);
    chk("R7 top lane", mem_be_n, 4'b0111);
    chk("R5 not both", (!mem_rd_n && !mem_wr_n), 0);
    host_req = 0;
    #1;
    chk("R8 idle nop", {mem_rd_n, mem_wr_n}, 2'b11);
    step();
  endtask

  task automatic t_restart();
    @(negedge clk); sys_rst_n = 0; host_req = 1;
    #1;
    chk("R9 ready drop", host_ready, 0);
    chk("R9 no strobe", {mem_rd_n, mem_wr_n}, 2'b11);
    @(negedge clk); sys_rst_n = 1;
    step(); step();
    chk("R9 restart reset", mem_rst_n, 0);
    chk("R8 not ready nop", {mem_rd_n, mem_wr_n}, 2'b11);
    repeat (140) step();
    chk("R9 ready again", host_ready, 1);
    host_req = 0;
  endtask

  initial begin
    t_bringup();
    t_access();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule